// File: doc/BRIEF.md
# Per-Flow Traffic Accounting Counters

This block keeps a packet counter and a byte counter for every entry of a hardware forwarding table. The forwarding pipeline reports each packet it forwards on an update port. The report carries the flow index, the frame length in bytes and the flow's own count-enable flag. An accepted report adds one to the flow's packet counter and adds the frame length to its byte counter. Both counters wrap modulo their widths: 48 bits for bytes and 40 bits for packets.

Software reads one flow at a time through a small word-addressed register interface. It writes the flow index together with a start bit, polls until the busy bit drops, and then reads three result words. The byte and packet counts are split across these words at uneven boundaries. A configuration register holds a global counting enable and a read-clear mode. In read-clear mode, each read returns the traffic seen since the previous read of that flow. The counter table depth is a parameter.

Top module: `flow_acct_top`

## Requirements
- R1: After reset, every counter is zero, the configuration register reads zero, the search-control register reads zero with busy low, and all three result words read zero.
- R2: An update with `upd_valid`, `upd_count_en` and the global enable all high adds 1 to the flow's packet counter and adds `upd_len` to its byte counter.
- R3: An update whose `upd_count_en` is low leaves the flow's counters unchanged.
- R4: The global enable is bit 0 of the configuration register (word address 0). While it is low, no update changes any counter.
- R5: A read starts when software writes word address 1 with the flow index in bits 13:0 and bit 16 set. Bit 16 of that word then reads 1 for exactly two clock cycles, which are the memory read and the capture. It then reads 0, and the result words are valid from that point.
- R6: Result word 0 (address 2) holds byte bits 31:0. Result word 1 (address 3) holds byte bits 47:32 in bits 15:0 and packet bits 15:0 in bits 31:16. Result word 2 (address 4) holds packet bits 39:16 in bits 23:0, and its bits 31:24 read zero.
- R7: With the read-clear bit set (bit 1 of the configuration register), both counters of the flow that was read are zeroed once they have been captured.
- R8: If an update reaches the flow being read-cleared in the capture cycle, the returned counts exclude that update. The stored counts then equal exactly that one update.
- R9: A read of an index at or above the table depth returns zero. An update to such an index changes no counter.
- R10: A write to the search-control register while busy is ignored. It neither changes the index being read nor starts another read.
- R11: An update that reaches the target flow during the memory-read cycle is included in the returned counts. One that arrives in the capture cycle, with read-clear off, is kept in the counter for the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | A forwarded packet is reported this cycle |
| upd_index | input | 14 | Flow index of the reported packet |
| upd_len | input | LEN_W | Frame length in bytes |
| upd_count_en | input | 1 | Per-flow count-enable flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |

## Verification
The assertions check the handshake on every cycle. Busy lasts exactly two cycles, the requested index holds while busy, and the result words move only on a capture. A clear happens only inside a lookup, and the top byte of result word 2 is always zero. The bench scenarios are needed for the arithmetic and the timing corners. These cover accumulation across several flows and lengths, and the effect of the two enables. They also cover updates that land in the read or the capture cycle, with and without read-clear, and indices beyond the table depth.

// File: rtl/flow_acct_pkg.sv
package flow_acct_pkg;

    localparam int BYTE_W      = 48;
    localparam int PKT_W       = 40;
    localparam int IDX_W       = 14;
    localparam int START_BIT   = 16;
    localparam int REG_ADDR_W  = 3;
    localparam int WORD_W      = 32;

    typedef struct packed {
        logic [BYTE_W-1:0] bytes;
        logic [PKT_W-1:0]  pkts;
    } flow_cnt_t;

    typedef struct packed {
        logic [WORD_W-1:0] w2;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w0;
    } result_words_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOOKUP  = 2'd1,
        ST_CAPTURE = 2'd2
    } srch_state_e;

    localparam logic [REG_ADDR_W-1:0] RA_CFG  = 3'd0;
    localparam logic [REG_ADDR_W-1:0] RA_CTL  = 3'd1;
    localparam logic [REG_ADDR_W-1:0] RA_RES0 = 3'd2;
    localparam logic [REG_ADDR_W-1:0] RA_RES1 = 3'd3;
    localparam logic [REG_ADDR_W-1:0] RA_RES2 = 3'd4;

    // Split the two counters across three words (R6).
    function automatic result_words_t pack_result(flow_cnt_t c);
        result_words_t r;
        r.w0 = c.bytes[31:0];
        r.w1 = {c.pkts[15:0], c.bytes[47:32]};
        r.w2 = {8'd0, c.pkts[39:16]};
        return r;
    endfunction

    function automatic flow_cnt_t add_packet(flow_cnt_t c, logic [BYTE_W-1:0] len);
        flow_cnt_t r;
        r.bytes = c.bytes + len;
        r.pkts  = c.pkts + PKT_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/flow_acct_table.sv
module flow_acct_table
    import flow_acct_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_hit,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [LEN_W-1:0] upd_len,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output flow_cnt_t        rd_data
);
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    flow_cnt_t cnt_q [DEPTH];
    flow_cnt_t one_pkt;

    assign one_pkt.bytes = BYTE_W'(upd_len);
    assign one_pkt.pkts  = PKT_W'(1);

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic upd_here;
        logic clr_here;
        assign upd_here = upd_hit && (upd_idx == IDX_W'(g));
        assign clr_here = clr_en && (clr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[g] <= '0;
            end else if (clr_here) begin
                // Same-cycle update survives the clear (R8).
                cnt_q[g] <= upd_here ? one_pkt : '0;
            end else if (upd_here) begin
                cnt_q[g] <= add_packet(cnt_q[g], BYTE_W'(upd_len));
            end
        end
    end

    always_comb begin
        if ({1'b0, rd_idx} < (IDX_W+1)'(DEPTH)) begin
            rd_data = cnt_q[rd_idx[ADDR_W-1:0]];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/flow_acct_regs.sv
module flow_acct_regs
    import flow_acct_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]     reg_wdata,
    output logic [WORD_W-1:0]     reg_rdata,
    output logic                  cfg_en,
    output logic [IDX_W-1:0]      req_idx,
    output logic                  busy,
    output logic                  capture,
    output logic                  clr_en,
    output result_words_t         res,
    input  flow_cnt_t             rd_data
);
    srch_state_e   state_q;
    srch_state_e   state_d;
    logic          cfg_en_q;
    logic          cfg_clr_q;
    logic [IDX_W-1:0] idx_q;
    result_words_t res_q;
    logic          ctl_wr_idle;
    logic          start_req;

    assign ctl_wr_idle = reg_wr && (reg_addr == RA_CTL) && (state_q == ST_IDLE);
    assign start_req   = ctl_wr_idle && reg_wdata[START_BIT];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_req) state_d = ST_LOOKUP;
            ST_LOOKUP:  state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cfg_en_q  <= 1'b0;
            cfg_clr_q <= 1'b0;
            idx_q     <= '0;
            res_q     <= '0;
        end else begin
            state_q <= state_d;
            if (reg_wr && (reg_addr == RA_CFG)) begin
                cfg_en_q  <= reg_wdata[0];
                cfg_clr_q <= reg_wdata[1];
            end
            if (ctl_wr_idle) begin
                idx_q <= reg_wdata[IDX_W-1:0];
            end
            if (state_q == ST_CAPTURE) begin
                res_q <= pack_result(rd_data);
            end
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign capture = (state_q == ST_CAPTURE);
    assign clr_en  = capture && cfg_clr_q;
    assign cfg_en  = cfg_en_q;
    assign req_idx = idx_q;
    assign res     = res_q;

    always_comb begin
        unique case (reg_addr)
            RA_CFG:  reg_rdata = {30'd0, cfg_clr_q, cfg_en_q};
            RA_CTL:  reg_rdata = {15'd0, busy, 2'd0, idx_q};
            RA_RES0: reg_rdata = res_q.w0;
            RA_RES1: reg_rdata = res_q.w1;
            RA_RES2: reg_rdata = res_q.w2;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/flow_acct_top.sv
module flow_acct_top
    import flow_acct_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_valid,
    input  logic [13:0]      upd_index,
    input  logic [LEN_W-1:0] upd_len,
    input  logic             upd_count_en,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata
);
    logic          cfg_en;
    logic          busy;
    logic          capture;
    logic          clr_en;
    logic [IDX_W-1:0] req_idx;
    result_words_t res;
    flow_cnt_t     rd_data;
    logic          upd_hit;

    assign upd_hit = upd_valid && upd_count_en && cfg_en;

    flow_acct_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_en    (cfg_en),
        .req_idx   (req_idx),
        .busy      (busy),
        .capture   (capture),
        .clr_en    (clr_en),
        .res       (res),
        .rd_data   (rd_data)
    );

    flow_acct_table #(
        .DEPTH (DEPTH),
        .LEN_W (LEN_W)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .upd_hit (upd_hit),
        .upd_idx (upd_index),
        .upd_len (upd_len),
        .clr_en  (clr_en),
        .clr_idx (req_idx),
        .rd_idx  (req_idx),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/flow_acct_checker.sv
module flow_acct_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        capture,
    input logic        clr_en,
    input logic [13:0] req_idx,
    input logic [95:0] res,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_rdata
);

    assert_busy_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

    assert_busy_two_cycles_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> !busy);

    assert_index_held_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(req_idx));

    assert_result_only_on_capture_R5: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(res));

    assert_clear_inside_lookup_R7: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> busy);

    assert_word2_top_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 3'd4) |-> (reg_rdata[31:24] == 8'd0));

endmodule

bind flow_acct_top flow_acct_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .capture   (capture),
    .clr_en    (clr_en),
    .req_idx   (req_idx),
    .res       (res),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/test_flow_acct_top.sv
module test_flow_acct_top;

    localparam int DEPTH = 64;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             upd_valid = 1'b0;
    logic [13:0]      upd_index = '0;
    logic [LEN_W-1:0] upd_len = '0;
    logic             upd_count_en = 1'b0;
    logic             reg_wr = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    flow_acct_top #(.DEPTH(DEPTH), .LEN_W(LEN_W)) i_flow_acct_top (
        .clk          (clk),
        .rst          (rst),
        .upd_valid    (upd_valid),
        .upd_index    (upd_index),
        .upd_len      (upd_len),
        .upd_count_en (upd_count_en),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata)
    );

    typedef struct packed {
        logic [13:0] idx;
        logic [15:0] len;
        logic        cen;
        logic [47:0] exp_bytes;
        logic [39:0] exp_pkts;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{idx: 14'd3,  len: 16'd100,   cen: 1'b1, exp_bytes: 48'd100,   exp_pkts: 40'd1},
        '{idx: 14'd3,  len: 16'd60,    cen: 1'b1, exp_bytes: 48'd160,   exp_pkts: 40'd2},
        '{idx: 14'd3,  len: 16'd500,   cen: 1'b0, exp_bytes: 48'd160,   exp_pkts: 40'd2},
        '{idx: 14'd10, len: 16'd1500,  cen: 1'b1, exp_bytes: 48'd1500,  exp_pkts: 40'd1},
        '{idx: 14'd63, len: 16'd65535, cen: 1'b1, exp_bytes: 48'd65535, exp_pkts: 40'd1},
        '{idx: 14'd63, len: 16'd1,     cen: 1'b1, exp_bytes: 48'd65536, exp_pkts: 40'd2},
        '{idx: 14'd64, len: 16'd77,    cen: 1'b1, exp_bytes: 48'd0,     exp_pkts: 40'd0},
        '{idx: 14'd10, len: 16'd0,     cen: 1'b1, exp_bytes: 48'd1500,  exp_pkts: 40'd2}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send_upd(input logic [13:0] idx, input logic [15:0] len, input logic cen);
        @(negedge clk);
        upd_valid = 1'b1; upd_index = idx; upd_len = len; upd_count_en = cen;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // slot: 0 none, 1 update in read cycle, 2 update in capture cycle,
    // 3 second start write while busy (index 63)
    task automatic read_flow(input logic [13:0] idx, input int slot, input logic [15:0] inj_len,
                             output logic [47:0] b, output logic [39:0] p);
        logic [31:0] w0, w1, w2, c;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0001_0000 | 32'(idx);
        @(negedge clk);
        reg_wr = 1'b0;
        if (slot == 1) begin
            upd_valid = 1'b1; upd_index = idx; upd_len = inj_len; upd_count_en = 1'b1;
        end
        if (slot == 3) begin
            reg_wr = 1'b1; reg_wdata = 32'h0001_003F;
        end
        reg_read(3'd1, c);
        check("R5 busy cycle 1", 64'(c[16]), 64'd1);
        @(negedge clk);
        reg_wr = 1'b0; upd_valid = 1'b0;
        if (slot == 2) begin
            upd_valid = 1'b1; upd_index = idx; upd_len = inj_len; upd_count_en = 1'b1;
        end
        reg_read(3'd1, c);
        check("R5 busy cycle 2", 64'(c[16]), 64'd1);
        @(negedge clk);
        upd_valid = 1'b0;
        reg_read(3'd1, c);
        check("R5 busy clear", 64'(c[16]), 64'd0);
        reg_read(3'd2, w0);
        reg_read(3'd3, w1);
        reg_read(3'd4, w2);
        b = {w1[15:0], w0};
        p = {w2[23:0], w1[31:16]};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R5 actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [47:0] b;
        logic [39:0] p;
        string tag;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            reg_read(3'(a), d);
            check("R1 register reset", 64'(d), 64'd0);
        end
        reg_write(3'd0, 32'd1);
        read_flow(14'd3, 0, 16'd0, b, p);
        check("R1 counter bytes", 64'(b), 64'd0);
        check("R1 counter pkts", 64'(p), 64'd0);

        // Vector table: R2, R3, R9
        for (int i = 0; i < NVEC; i++) begin
            send_upd(VECS[i].idx, VECS[i].len, VECS[i].cen);
            read_flow(VECS[i].idx, 0, 16'd0, b, p);
            if (!VECS[i].cen) tag = "R3";
            else if (VECS[i].idx >= 14'(DEPTH)) tag = "R9";
            else tag = "R2";
            check({tag, " bytes"}, 64'(b), 64'(VECS[i].exp_bytes));
            check({tag, " pkts"}, 64'(p), 64'(VECS[i].exp_pkts));
        end

        // R9: out-of-range update did not alias onto flow 0
        read_flow(14'd0, 0, 16'd0, b, p);
        check("R9 no alias bytes", 64'(b), 64'd0);
        check("R9 no alias pkts", 64'(p), 64'd0);

        // R6 raw word layout for flow 63 (65536 bytes, 2 packets)
        read_flow(14'd63, 0, 16'd0, b, p);
        reg_read(3'd2, d); check("R6 word0", 64'(d), 64'd65536);
        reg_read(3'd3, d); check("R6 word1", 64'(d), 64'h0002_0000);
        reg_read(3'd4, d); check("R6 word2", 64'(d), 64'd0);

        // R4 global enable off
        reg_write(3'd0, 32'd0);
        reg_read(3'd0, d); check("R4 config readback", 64'(d), 64'd0);
        send_upd(14'd3, 16'd9, 1'b1);
        read_flow(14'd3, 0, 16'd0, b, p);
        check("R4 bytes", 64'(b), 64'd160);
        check("R4 pkts", 64'(p), 64'd2);
        reg_write(3'd0, 32'd1);

        // R11 updates inside the lookup window
        read_flow(14'd10, 1, 16'd5, b, p);
        check("R11 read-cycle bytes", 64'(b), 64'd1505);
        check("R11 read-cycle pkts", 64'(p), 64'd3);
        read_flow(14'd10, 2, 16'd7, b, p);
        check("R11 capture-cycle bytes", 64'(b), 64'd1505);
        check("R11 capture-cycle pkts", 64'(p), 64'd3);
        read_flow(14'd10, 0, 16'd0, b, p);
        check("R11 kept bytes", 64'(b), 64'd1512);
        check("R11 kept pkts", 64'(p), 64'd4);

        // R10 start while busy ignored
        read_flow(14'd3, 3, 16'd0, b, p);
        check("R10 bytes", 64'(b), 64'd160);
        check("R10 pkts", 64'(p), 64'd2);
        reg_read(3'd1, d);
        check("R10 index kept", 64'(d[13:0]), 64'd3);
        check("R10 no second read", 64'(d[16]), 64'd0);

        // R7 / R8 read-clear
        reg_write(3'd0, 32'd3);
        read_flow(14'd3, 2, 16'd40, b, p);
        check("R7 returned bytes", 64'(b), 64'd160);
        check("R7 returned pkts", 64'(p), 64'd2);
        read_flow(14'd3, 0, 16'd0, b, p);
        check("R8 stored bytes", 64'(b), 64'd40);
        check("R8 stored pkts", 64'(p), 64'd1);
        read_flow(14'd3, 0, 16'd0, b, p);
        check("R7 cleared bytes", 64'(b), 64'd0);
        check("R7 cleared pkts", 64'(p), 64'd0);
        read_flow(14'd10, 0, 16'd0, b, p);
        check("R7 other flow bytes", 64'(b), 64'd1512);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule